// File: doc/BRIEF.md
# Program Counter Sequencer with Conditional Skip

This block is the program-flow unit of a small 8-bit accumulator processor. It owns the program counter and, for every decoded instruction handed to it, works out where the next fetch comes from: the following instruction, a relative, page or long jump target, an entry from a lookup table indexed by the accumulator, a return address saved on a byte-wide data stack, or a two-byte vector held in program memory.

Conditional instructions do not branch. A test that comes out false arms a skip flag, and the next instruction presented is still stepped over by its length but does nothing else: it jumps nowhere, reads no memory and touches no stack. Instructions that need memory or stack traffic take several cycles, and `busy` is high while they run. Decode, the ALU and the memory arrays are outside the block. Program memory is read through a synchronous port with one cycle of latency, and the stack is reached through a push/pop port whose read data also arrives one cycle after the pop.

Top module: `pcseq_top`

## Requirements
- R1: A synchronous active-high reset sets `pc` to 0 and clears `skip_pending`, `busy`, `pm_rd`, `stk_push` and `stk_pop`.
- R2: A command is accepted on a clock edge where `cmd_valid` is high and `busy` is low. Opcode 0 (step) and opcode 1 (test), and the unused opcodes 10 to 15, set `pc` to `pc + cmd_len` modulo 2^15.
- R3: Opcode 2 (relative jump) sets `pc` to `pc + cmd_len + sign_extend(cmd_imm[7:0])` modulo 2^15.
- R4: Opcode 3 (page jump) keeps bits 14:12 of `pc + cmd_len` and takes bits 11:0 from `cmd_imm`. Opcode 4 (long jump) loads all 15 bits of `cmd_imm`.
- R5: Opcode 5 (table jump) reads program memory at `{pc[14:8], acc}` and writes the returned byte into `pc[7:0]`. `pc[14:8]` does not change. Example: with `pc[14:8]` = 01h, `acc` = 26h and the byte 32h stored at 0126h, `pc` becomes 0132h.
- R6: Opcode 6 (call) pushes the return address `pc + cmd_len` as two bytes, the low byte first and then `{1'b0, high 7 bits}`, and then sets `pc` to `cmd_imm`.
- R7: Opcode 7 (return) pops two bytes. The first byte popped supplies `pc[14:8]` from its bits 6:0, and the second byte supplies `pc[7:0]`. Opcode 8 does the same and also sets `skip_pending`.
- R8: Opcode 9 (vector) reads the high byte at `{cmd_imm[14:1], 0}` and the low byte at the next address, then loads `pc` with `{high[6:0], low}`.
- R9: A test (opcode 1) with `cmd_cond` = 0 sets `skip_pending`. With `cmd_cond` = 1 it leaves the flag clear.
- R10: While `skip_pending` is set, the next accepted command of any opcode only advances `pc` by `cmd_len`, raises no memory or stack strobe, sets no skip, and clears `skip_pending`.
- R11: `busy` stays high for 2 cycles after a table jump or call, for 3 cycles after a vector or either return, and for 0 cycles otherwise. Commands presented while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Decoded instruction present |
| cmd_op | input | 4 | Flow opcode (see requirements) |
| cmd_len | input | 2 | Length of the current instruction in bytes |
| cmd_imm | input | PC_W | Immediate target or offset |
| cmd_cond | input | 1 | Test outcome for opcode 1 |
| acc | input | 8 | Accumulator value |
| pc | output | PC_W | Program counter |
| busy | output | 1 | Multi-cycle operation in progress |
| skip_pending | output | 1 | Next instruction will be executed as a no-op |
| pm_rd | output | 1 | Program-memory read strobe |
| pm_addr | output | PC_W | Program-memory read address |
| pm_data | input | 8 | Program-memory read data, one cycle after `pm_rd` |
| stk_push | output | 1 | Stack push strobe |
| stk_pop | output | 1 | Stack pop strobe |
| stk_wdata | output | 8 | Byte to push |
| stk_rdata | input | 8 | Popped byte, one cycle after `stk_pop` |

## Verification
The bench builds the block with PC_W = 15 and PAGE_W = 12, so the 32K address space wraps in both directions and the top bits of the page are carried through page jumps. With a 7-bit high byte, bit 7 of a popped or vector high byte is visibly dropped, and the pseudo-random memory contents put arbitrary values there. A 64-entry stack model lets call and return nest deeply, and skipped calls and returns can be checked against the stack pointer.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  localparam logic [3:0] OP_STEP  = 4'd0;
  localparam logic [3:0] OP_TEST  = 4'd1;
  localparam logic [3:0] OP_JREL  = 4'd2;
  localparam logic [3:0] OP_JPAGE = 4'd3;
  localparam logic [3:0] OP_JLONG = 4'd4;
  localparam logic [3:0] OP_JTAB  = 4'd5;
  localparam logic [3:0] OP_CALL  = 4'd6;
  localparam logic [3:0] OP_RET   = 4'd7;
  localparam logic [3:0] OP_RETSK = 4'd8;
  localparam logic [3:0] OP_VEC   = 4'd9;

  typedef enum logic [3:0] {
    ST_IDLE, ST_TAB_REQ, ST_TAB_DAT,
    ST_VEC_REQ, ST_VEC_HI, ST_VEC_LO,
    ST_CALL_HI, ST_CALL_FIN,
    ST_RET_REQ, ST_RET_HI, ST_RET_LO
  } seq_state_e;
endpackage

// File: rtl/pcseq_target.sv
module pcseq_target
  import pcseq_pkg::*;
#(
  parameter int PC_W   = 15,
  parameter int PAGE_W = 12
) (
  input  logic [PC_W-1:0] pc,
  input  logic [1:0]      len,
  input  logic [3:0]      op,
  input  logic [PC_W-1:0] imm,
  output logic [PC_W-1:0] seq_pc,
  output logic [PC_W-1:0] direct_pc
);
  localparam int EXT_W = PC_W - 8;

  logic [PC_W-1:0] rel_pc;
  logic [PC_W-1:0] page_pc;

  always_comb begin
    seq_pc  = pc + PC_W'(len);
    rel_pc  = seq_pc + {{EXT_W{imm[7]}}, imm[7:0]};
    page_pc = {seq_pc[PC_W-1:PAGE_W], imm[PAGE_W-1:0]};
    case (op)
      OP_JREL:  direct_pc = rel_pc;
      OP_JPAGE: direct_pc = page_pc;
      OP_JLONG: direct_pc = imm;
      default:  direct_pc = seq_pc;
    endcase
  end
endmodule

// File: rtl/pcseq_skip.sv
module pcseq_skip (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic consume,
  output logic skip_q
);
  always_ff @(posedge clk) begin
    if (rst)          skip_q <= 1'b0;
    else if (arm)     skip_q <= 1'b1;
    else if (consume) skip_q <= 1'b0;
  end

  // R10: a skipped instruction never arms another skip
  assert_arm_consume_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(arm && consume));
endmodule

// File: rtl/pcseq_ctrl.sv
module pcseq_ctrl
  import pcseq_pkg::*;
#(
  parameter int PC_W = 15
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  input  logic [3:0]      cmd_op,
  input  logic [PC_W-1:0] cmd_imm,
  input  logic            cmd_cond,
  input  logic [7:0]      acc,
  input  logic [PC_W-1:0] seq_pc,
  input  logic [PC_W-1:0] direct_pc,
  input  logic            skip,
  output logic            skip_arm,
  output logic            skip_consume,
  output logic [PC_W-1:0] pc,
  output logic            busy,
  output logic            pm_rd,
  output logic [PC_W-1:0] pm_addr,
  input  logic [7:0]      pm_data,
  output logic            stk_push,
  output logic            stk_pop,
  output logic [7:0]      stk_wdata,
  input  logic [7:0]      stk_rdata
);
  localparam int HI_W = PC_W - 8;

  seq_state_e      state;
  logic [PC_W-1:0] hold;
  logic [7:0]      hi_byte;
  logic            ret_sk;
  logic            accept;

  assign busy         = (state != ST_IDLE);
  assign accept       = cmd_valid && (state == ST_IDLE);
  assign skip_consume = accept && skip;
  assign skip_arm     = (accept && !skip && cmd_op == OP_TEST && !cmd_cond) ||
                        (state == ST_RET_LO && ret_sk);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      pc        <= '0;
      pm_rd     <= 1'b0;
      pm_addr   <= '0;
      stk_push  <= 1'b0;
      stk_pop   <= 1'b0;
      stk_wdata <= '0;
      hold      <= '0;
      hi_byte   <= '0;
      ret_sk    <= 1'b0;
    end else begin
      pm_rd    <= 1'b0;
      stk_push <= 1'b0;
      stk_pop  <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          if (skip) begin
            pc <= seq_pc;
          end else begin
            case (cmd_op)
              OP_JTAB: begin
                pm_rd   <= 1'b1;
                pm_addr <= {pc[PC_W-1:8], acc};
                state   <= ST_TAB_REQ;
              end
              OP_VEC: begin
                pm_rd   <= 1'b1;
                pm_addr <= {cmd_imm[PC_W-1:1], 1'b0};
                state   <= ST_VEC_REQ;
              end
              OP_CALL: begin
                stk_push  <= 1'b1;
                stk_wdata <= seq_pc[7:0];
                hi_byte   <= 8'(seq_pc[PC_W-1:8]);
                hold      <= cmd_imm;
                state     <= ST_CALL_HI;
              end
              OP_RET, OP_RETSK: begin
                stk_pop <= 1'b1;
                ret_sk  <= (cmd_op == OP_RETSK);
                state   <= ST_RET_REQ;
              end
              default: pc <= direct_pc;
            endcase
          end
        end
        ST_TAB_REQ: state <= ST_TAB_DAT;
        ST_TAB_DAT: begin
          pc[7:0] <= pm_data;
          state   <= ST_IDLE;
        end
        ST_VEC_REQ: begin
          pm_rd   <= 1'b1;
          pm_addr <= pm_addr | PC_W'(1);
          state   <= ST_VEC_HI;
        end
        ST_VEC_HI: begin
          hi_byte <= pm_data;
          state   <= ST_VEC_LO;
        end
        ST_VEC_LO: begin
          pc    <= {hi_byte[HI_W-1:0], pm_data};
          state <= ST_IDLE;
        end
        ST_CALL_HI: begin
          stk_push  <= 1'b1;
          stk_wdata <= hi_byte;
          state     <= ST_CALL_FIN;
        end
        ST_CALL_FIN: begin
          pc    <= hold;
          state <= ST_IDLE;
        end
        ST_RET_REQ: begin
          stk_pop <= 1'b1;
          state   <= ST_RET_HI;
        end
        ST_RET_HI: begin
          hi_byte <= stk_rdata;
          state   <= ST_RET_LO;
        end
        ST_RET_LO: begin
          pc    <= {hi_byte[HI_W-1:0], stk_rdata};
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (pc == '0 && !busy && !pm_rd && !stk_push && !stk_pop));

  assert_skip_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (accept && skip) |=> (!pm_rd && !stk_push && !stk_pop && !busy));

  assert_tab_keeps_high_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TAB_DAT) |=> (pc[PC_W-1:8] == $past(pc[PC_W-1:8])));

  assert_vec_even_first_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_VEC_REQ) |-> (pm_rd && !pm_addr[0]));

  assert_push_pair_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(stk_push) |=> stk_push);

  assert_pop_pair_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(stk_pop) |=> stk_pop);

  assert_pc_frozen_busy_R11: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TAB_REQ || state == ST_VEC_REQ || state == ST_VEC_HI ||
     state == ST_CALL_HI || state == ST_RET_REQ || state == ST_RET_HI)
    |=> $stable(pc));
endmodule

// File: rtl/pcseq_top.sv
module pcseq_top
  import pcseq_pkg::*;
#(
  parameter int PC_W   = 15,
  parameter int PAGE_W = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  input  logic [3:0]      cmd_op,
  input  logic [1:0]      cmd_len,
  input  logic [PC_W-1:0] cmd_imm,
  input  logic            cmd_cond,
  input  logic [7:0]      acc,
  output logic [PC_W-1:0] pc,
  output logic            busy,
  output logic            skip_pending,
  output logic            pm_rd,
  output logic [PC_W-1:0] pm_addr,
  input  logic [7:0]      pm_data,
  output logic            stk_push,
  output logic            stk_pop,
  output logic [7:0]      stk_wdata,
  input  logic [7:0]      stk_rdata
);
  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] direct_pc;
  logic            skip_arm;
  logic            skip_consume;

  pcseq_target #(.PC_W(PC_W), .PAGE_W(PAGE_W)) u_target (
    .pc(pc), .len(cmd_len), .op(cmd_op), .imm(cmd_imm),
    .seq_pc(seq_pc), .direct_pc(direct_pc)
  );

  pcseq_skip u_skip (
    .clk(clk), .rst(rst), .arm(skip_arm), .consume(skip_consume),
    .skip_q(skip_pending)
  );

  pcseq_ctrl #(.PC_W(PC_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_imm(cmd_imm),
    .cmd_cond(cmd_cond), .acc(acc),
    .seq_pc(seq_pc), .direct_pc(direct_pc), .skip(skip_pending),
    .skip_arm(skip_arm), .skip_consume(skip_consume),
    .pc(pc), .busy(busy),
    .pm_rd(pm_rd), .pm_addr(pm_addr), .pm_data(pm_data),
    .stk_push(stk_push), .stk_pop(stk_pop),
    .stk_wdata(stk_wdata), .stk_rdata(stk_rdata)
  );
endmodule

// File: tb/pcseq_top_bench.sv
module pcseq_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 15;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            cmd_valid = 1'b0;
  logic [3:0]      cmd_op = '0;
  logic [1:0]      cmd_len = '0;
  logic [PC_W-1:0] cmd_imm = '0;
  logic            cmd_cond = 1'b0;
  logic [7:0]      acc = '0;
  logic [PC_W-1:0] pc;
  logic            busy, skip_pending, pm_rd, stk_push, stk_pop;
  logic [PC_W-1:0] pm_addr;
  logic [7:0]      pm_data = '0;
  logic [7:0]      stk_wdata;
  logic [7:0]      stk_rdata = '0;

  logic [7:0]      stk_mem [0:63];
  logic [5:0]      sp = '0;
  logic [7:0]      m_stk [0:63];
  logic [5:0]      m_sp;
  logic [PC_W-1:0] m_pc;
  logic            m_skip;
  int nchk = 0;
  int nerr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcseq_top u_pcseq_top (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_len(cmd_len), .cmd_imm(cmd_imm), .cmd_cond(cmd_cond), .acc(acc),
    .pc(pc), .busy(busy), .skip_pending(skip_pending),
    .pm_rd(pm_rd), .pm_addr(pm_addr), .pm_data(pm_data),
    .stk_push(stk_push), .stk_pop(stk_pop),
    .stk_wdata(stk_wdata), .stk_rdata(stk_rdata)
  );

  function automatic logic [7:0] pm_byte(input logic [PC_W-1:0] a);
    if (a == 15'h0126) return 8'h32;
    return (a[7:0] * 8'd29) ^ ({1'b0, a[14:8]} + 8'd7);
  endfunction

  always @(posedge clk) begin
    if (pm_rd) pm_data <= pm_byte(pm_addr);
    if (stk_pop) begin
      stk_rdata <= stk_mem[sp - 6'd1];
      sp <= sp - 6'd1;
    end
    if (stk_push) begin
      stk_mem[sp] <= stk_wdata;
      sp <= sp + 6'd1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [3:0] op, input logic [1:0] len,
                     input logic [PC_W-1:0] imm, input logic [7:0] a,
                     input logic cond, input bit junk, input string tag);
    logic [PC_W-1:0] seq, base;
    logic [7:0] hi, lo;
    int exp_busy, cycles;
    exp_busy = 0;
    seq = m_pc + PC_W'(len);
    if (m_skip) begin
      m_pc = seq; m_skip = 1'b0;
    end else begin
      case (op)
        4'd1: begin m_pc = seq; m_skip = !cond; end
        4'd2: m_pc = seq + {{7{imm[7]}}, imm[7:0]};
        4'd3: m_pc = {seq[14:12], imm[11:0]};
        4'd4: m_pc = imm;
        4'd5: begin
          lo = pm_byte({m_pc[14:8], a});
          m_pc = {m_pc[14:8], lo}; exp_busy = 2;
        end
        4'd6: begin
          m_stk[m_sp] = seq[7:0];
          m_stk[m_sp + 6'd1] = {1'b0, seq[14:8]};
          m_sp = m_sp + 6'd2; m_pc = imm; exp_busy = 2;
        end
        4'd7, 4'd8: begin
          hi = m_stk[m_sp - 6'd1]; lo = m_stk[m_sp - 6'd2];
          m_sp = m_sp - 6'd2; m_pc = {hi[6:0], lo}; exp_busy = 3;
          if (op == 4'd8) m_skip = 1'b1;
        end
        4'd9: begin
          base = {imm[14:1], 1'b0};
          hi = pm_byte(base); lo = pm_byte(base | 15'd1);
          m_pc = {hi[6:0], lo}; exp_busy = 3;
        end
        default: m_pc = seq;
      endcase
    end
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_len = len; cmd_imm = imm;
    acc = a; cmd_cond = cond;
    @(negedge clk);
    cycles = 0;
    while (busy && cycles < 20) begin
      cycles++;
      cmd_valid = junk;
      cmd_op = 4'($urandom); cmd_imm = 15'($urandom); acc = 8'($urandom);
      cmd_cond = 1'b0; cmd_len = 2'($urandom);
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    chk(pc == m_pc, tag, 32'(pc), 32'(m_pc));
    chk(skip_pending == m_skip, "R9 R10 skip flag", 32'(skip_pending), 32'(m_skip));
    chk(cycles == exp_busy, "R11 busy cycles", 32'(cycles), 32'(exp_busy));
    chk(sp == m_sp, "R6 R7 R10 stack depth", 32'(sp), 32'(m_sp));
    if (m_sp >= 6'd2) begin
      chk(stk_mem[m_sp - 6'd1] == m_stk[m_sp - 6'd1], "R6 pushed high byte",
          32'(stk_mem[m_sp - 6'd1]), 32'(m_stk[m_sp - 6'd1]));
      chk(stk_mem[m_sp - 6'd2] == m_stk[m_sp - 6'd2], "R6 pushed low byte",
          32'(stk_mem[m_sp - 6'd2]), 32'(m_stk[m_sp - 6'd2]));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    nchk++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    int seed_val;
    logic [3:0] op;
    seed_val = $urandom(32'd4242);
    m_pc = '0; m_skip = 1'b0; m_sp = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(pc == '0, "R1 pc after reset", 32'(pc), 0);
    chk(!busy && !skip_pending, "R1 busy/skip after reset",
        {30'd0, busy, skip_pending}, 0);
    chk(!pm_rd && !stk_push && !stk_pop, "R1 strobes after reset",
        {29'd0, pm_rd, stk_push, stk_pop}, 0);

    // R5 table jump example: high 01h, acc 26h -> 0132h
    run(4'd4, 2'd1, 15'h0100, 8'h00, 1'b0, 0, "R4 long jump");
    run(4'd5, 2'd1, 15'h0000, 8'h26, 1'b0, 0, "R5 table jump example");
    chk(pc == 15'h0132, "R5 literal 0132h", 32'(pc), 32'h132);
    // R9 false test, R10 skipped call does nothing but step
    run(4'd1, 2'd1, '0, '0, 1'b0, 0, "R2 test step");
    run(4'd6, 2'd3, 15'h5555, '0, 1'b0, 0, "R10 skipped call");
    run(4'd1, 2'd2, '0, '0, 1'b1, 0, "R9 true test");
    // R7 call then return-and-skip, then a skipped long jump
    run(4'd6, 2'd3, 15'h5555, '0, 1'b0, 0, "R6 call");
    run(4'd8, 2'd1, '0, '0, 1'b0, 0, "R7 return and skip");
    run(4'd4, 2'd3, 15'h7777, '0, 1'b0, 0, "R10 skipped long jump");
    // R3 wrap below zero
    run(4'd4, 2'd1, 15'h0000, '0, 1'b0, 0, "R4 long jump zero");
    run(4'd2, 2'd1, 15'h0080, '0, 1'b0, 0, "R3 relative wrap");
    chk(pc == 15'h7F81, "R3 literal 7F81h", 32'(pc), 32'h7F81);
    // R8 odd vector address uses even base
    run(4'd9, 2'd1, 15'h2345, '0, 1'b0, 0, "R8 vector odd imm");
    run(4'd3, 2'd2, 15'h0ABC, '0, 1'b0, 0, "R4 page jump");
    // R11 commands presented while busy are ignored
    run(4'd5, 2'd1, '0, 8'h9C, 1'b0, 1, "R11 table jump with junk");
    run(4'd6, 2'd2, 15'h1234, '0, 1'b0, 1, "R11 call with junk");
    run(4'd7, 2'd1, '0, '0, 1'b0, 1, "R11 return with junk");
    run(4'd12, 2'd3, 15'h7FFF, '0, 1'b0, 0, "R2 unused opcode");

    for (int i = 0; i < 400; i++) begin
      op = 4'($urandom % 13);
      if ((op == 4'd7 || op == 4'd8) && m_sp < 6'd2) op = 4'd6;
      if (op == 4'd6 && m_sp > 6'd56) op = 4'd7;
      run(op, 2'($urandom), 15'($urandom), 8'($urandom), 1'($urandom),
          1'($urandom), "R2-R8 random op");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule